// File: doc/BRIEF.md
# Keccak Chi Step SIMD Unit

This unit performs the nonlinear chi step of the Keccak permutation on lanes packed into 128-bit operands. Each result lane combines three neighbouring lanes of a plane as `y[x] = a[x] ^ (~a[x+1] & a[x+2])`, with indices wrapping modulo five. Software keeps the state in wide registers and issues one operation per cycle. The operation kind is selected by `op_mode`.

The pair operation finishes several lanes at once. In the 2x64 view it yields two 64-bit lanes. In the 4x32 view it yields four 32-bit lanes. Two narrowing tail operations finish the fifth lane of a plane. The wide tail serves 64-bit lanes. The narrow tail serves 32-bit containers, which also carry 16-bit and 8-bit lanes.

For a plane of 64-bit lanes, two pair operations and one wide tail complete the plane. For smaller lanes, one pair operation in the 4x32 view and one narrow tail complete it. The datapath is combinational and ends in a single output register.

Top module: `chi_simd_unit`

## Requirements
- R1: While `rst` is high, `res_valid` and `res_data` are driven to zero at the next clock edge.
- R2: `res_valid` is high in exactly the cycle after a cycle in which `op_valid` was sampled high, so each accepted operation has a latency of one cycle.
- R3: Pair operation, 2x64 view (`op_mode`=1, `op_narrow_view`=0). Lanes are a0=`src_a[63:0]`, a1=`src_a[127:64]`, a2=`src_b[63:0]`, a3=`src_b[127:64]`. The result is `res_data[63:0]` = a0^(~a1&a2) and `res_data[127:64]` = a1^(~a2&a3).
- R4: Pair operation, 4x32 view (`op_mode`=1, `op_narrow_view`=1). Lane k of `src_a` (bits 32k+31:32k) is a_k for k=0..3, and a4=`src_b[31:0]`. Result word k is a_k^(~a_{k+1}&a_{k+2}), with indices taken modulo 5. `src_b[127:32]` has no effect.
- R5: Wide tail (`op_mode`=2). a4=`src_a[63:0]`, a0=`src_b[63:0]`, a1=`src_b[127:64]`. `res_data[63:0]` = a4^(~a0&a1), `res_data[127:64]` = 0, and `src_a[127:64]` has no effect.
- R6: Narrow tail (`op_mode`=3). a4=`src_a[31:0]`, a0=`src_b[31:0]`, a1=`src_b[63:32]`. `res_data[31:0]` = a4^(~a0&a1) and `res_data[127:32]` = 0. All other source bits have no effect.
- R7: `op_narrow_view` has no effect on the wide or narrow tail operations.
- R8: Mode 0 is reserved. It is accepted with `res_valid` high and returns an all-zero result.
- R9: While `op_valid` is low, `res_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_mode | input | 2 | 0 reserved, 1 pair, 2 wide tail, 3 narrow tail |
| op_narrow_view | input | 1 | Pair operation lane view: 0 = 2x64, 1 = 4x32 |
| src_a | input | 128 | First source operand |
| src_b | input | 128 | Second source operand |
| res_valid | output | 1 | Result registered this cycle |
| res_data | output | 128 | Registered result |

## Verification
Every result of every mode is due exactly one clock edge after the edge that samples its operation. The driver applies each operation on a falling edge and pushes the reference value, computed in the bench from R3 to R8, into a queue. The monitor samples one nanosecond after each rising edge. It pops one expected entry for every cycle in which `res_valid` is high, so any early, late or missing result misaligns the queue. On cycles with `res_valid` low, the monitor compares `res_data` against the last result to check the hold rule.

// File: rtl/chi_pkg.sv
package chi_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PAIR   = 2'd1,
    OP_WIDE   = 2'd2,
    OP_NARROW = 2'd3
  } chi_op_e;
endpackage

// File: rtl/chi_lane.sv
module chi_lane #(
  parameter int W = 64
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] nxt1,
  input  logic [W-1:0] nxt2,
  output logic [W-1:0] y
);
  assign y = cur ^ (~nxt1 & nxt2);
endmodule

// File: rtl/chi_pair_path.sv
module chi_pair_path #(
  parameter int LANE_W = 64
) (
  input  logic [2*LANE_W-1:0] src_a,
  input  logic [2*LANE_W-1:0] src_b,
  output logic [2*LANE_W-1:0] res_wide,
  output logic [2*LANE_W-1:0] res_narrow
);
  localparam int SUB_W  = LANE_W / 2;
  localparam int N_WIDE = 2;
  localparam int N_SUB  = 4;
  localparam int PLANE  = 5;

  // 2x64 view: four consecutive lanes taken from the two sources
  logic [LANE_W-1:0] wl [0:N_WIDE+1];
  assign wl[0] = src_a[LANE_W-1:0];
  assign wl[1] = src_a[2*LANE_W-1:LANE_W];
  assign wl[2] = src_b[LANE_W-1:0];
  assign wl[3] = src_b[2*LANE_W-1:LANE_W];

  genvar gi;
  generate
    for (gi = 0; gi < N_WIDE; gi++) begin : g_wide
      chi_lane #(.W(LANE_W)) u_lane (
        .cur (wl[gi]),
        .nxt1(wl[gi+1]),
        .nxt2(wl[gi+2]),
        .y   (res_wide[gi*LANE_W +: LANE_W])
      );
    end
  endgenerate

  // 4x32 view: five plane lanes, the fifth lives in the low word of src_b
  logic [SUB_W-1:0] sl [0:PLANE-1];
  generate
    for (gi = 0; gi < N_SUB; gi++) begin : g_sub_in
      assign sl[gi] = src_a[gi*SUB_W +: SUB_W];
    end
  endgenerate
  assign sl[PLANE-1] = src_b[SUB_W-1:0];

  generate
    for (gi = 0; gi < N_SUB; gi++) begin : g_sub
      chi_lane #(.W(SUB_W)) u_lane (
        .cur (sl[gi]),
        .nxt1(sl[(gi+1)%PLANE]),
        .nxt2(sl[(gi+2)%PLANE]),
        .y   (res_narrow[gi*SUB_W +: SUB_W])
      );
    end
  endgenerate
endmodule

// File: rtl/chi_tail_path.sv
module chi_tail_path #(
  parameter int LANE_W = 64
) (
  input  logic [2*LANE_W-1:0] src_a,
  input  logic [2*LANE_W-1:0] src_b,
  output logic [LANE_W-1:0]   tail_wide,
  output logic [LANE_W/2-1:0] tail_narrow
);
  localparam int SUB_W = LANE_W / 2;

  // fifth lane from src_a low part, wrapped lanes 0 and 1 from src_b
  chi_lane #(.W(LANE_W)) u_wide (
    .cur (src_a[LANE_W-1:0]),
    .nxt1(src_b[LANE_W-1:0]),
    .nxt2(src_b[2*LANE_W-1:LANE_W]),
    .y   (tail_wide)
  );

  chi_lane #(.W(SUB_W)) u_narrow (
    .cur (src_a[SUB_W-1:0]),
    .nxt1(src_b[SUB_W-1:0]),
    .nxt2(src_b[2*SUB_W-1:SUB_W]),
    .y   (tail_narrow)
  );
endmodule

// File: rtl/chi_simd_unit.sv
module chi_simd_unit
  import chi_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [1:0]          op_mode,
  input  logic                op_narrow_view,
  input  logic [2*LANE_W-1:0] src_a,
  input  logic [2*LANE_W-1:0] src_b,
  output logic                res_valid,
  output logic [2*LANE_W-1:0] res_data
);
  localparam int DW    = 2 * LANE_W;
  localparam int SUB_W = LANE_W / 2;

  logic [DW-1:0]     pair_wide, pair_narrow, nxt_data;
  logic [LANE_W-1:0] tail_wide;
  logic [SUB_W-1:0]  tail_narrow;

  chi_pair_path #(.LANE_W(LANE_W)) u_pair (
    .src_a     (src_a),
    .src_b     (src_b),
    .res_wide  (pair_wide),
    .res_narrow(pair_narrow)
  );

  chi_tail_path #(.LANE_W(LANE_W)) u_tail (
    .src_a      (src_a),
    .src_b      (src_b),
    .tail_wide  (tail_wide),
    .tail_narrow(tail_narrow)
  );

  always_comb begin
    case (chi_op_e'(op_mode))
      OP_PAIR:   nxt_data = op_narrow_view ? pair_narrow : pair_wide;
      OP_WIDE:   nxt_data = {{(DW-LANE_W){1'b0}}, tail_wide};
      OP_NARROW: nxt_data = {{(DW-SUB_W){1'b0}}, tail_narrow};
      default:   nxt_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_data <= nxt_data;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (res_valid == $past(op_valid)));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_valid)) |-> $stable(res_data));

  // R5
  wide_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(op_mode) == 2'd2)
      |-> (res_data[DW-1:LANE_W] == '0));

  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(op_mode) == 2'd3)
      |-> (res_data[DW-1:SUB_W] == '0));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_valid) && $past(op_mode) == 2'd0)
      |-> (res_valid && res_data == '0));
endmodule

// File: tb/sim_chi_simd_unit.sv
module sim_chi_simd_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [1:0]   op_mode = 2'd0;
  logic         op_narrow_view = 1'b0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic         res_valid;
  logic [127:0] res_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [127:0] exp_q [$];
  string        tag_q [$];
  logic [127:0] last_res = '0;
  bit           monitor_on = 1'b0;

  always #2 clk = ~clk;

  chi_simd_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_mode(op_mode),
    .op_narrow_view(op_narrow_view), .src_a(src_a), .src_b(src_b),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [63:0] f64(logic [63:0] a, logic [63:0] b, logic [63:0] c);
    return a ^ (~b & c);
  endfunction
  function automatic logic [31:0] f32(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    return a ^ (~b & c);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] model(logic [1:0] m, logic nv,
                                         logic [127:0] a, logic [127:0] b);
    logic [31:0] w [0:4];
    logic [127:0] r;
    r = '0;
    case (m)
      2'd1: if (!nv) begin
              r[63:0]   = f64(a[63:0],   a[127:64], b[63:0]);
              r[127:64] = f64(a[127:64], b[63:0],   b[127:64]);
            end else begin
              for (int k = 0; k < 4; k++) w[k] = a[32*k +: 32];
              w[4] = b[31:0];
              for (int k = 0; k < 4; k++)
                r[32*k +: 32] = f32(w[k], w[(k+1)%5], w[(k+2)%5]);
            end
      2'd2: r[63:0] = f64(a[63:0], b[63:0], b[127:64]);
      2'd3: r[31:0] = f32(a[31:0], b[31:0], b[63:32]);
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic drive(input logic [1:0] m, input logic nv,
                       input logic [127:0] a, input logic [127:0] b,
                       input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_mode = m; op_narrow_view = nv; src_a = a; src_b = b;
    exp_q.push_back(model(m, nv, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0; src_a = rnd128(); src_b = rnd128(); op_mode = 2'($urandom);
    end
  endtask

  // monitor: scoreboard pop one nanosecond after each rising edge
  always @(posedge clk) begin
    #1;
    if (monitor_on) begin
      if (res_valid) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R2 unexpected result act=%h exp=<none>", res_data);
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (res_data !== e) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", t, res_data, e);
          end
        end
        last_res = res_data;
      end else begin
        // R9 hold while idle; R2 nothing pending must remain
        n_cmp++;
        if (res_data !== last_res || exp_q.size() != 0) begin
          n_bad++;
          $display("FAIL R9/R2 idle act=%h exp=%h pending=%0d", res_data, last_res, exp_q.size());
        end
      end
    end
  end

  initial begin
    logic [127:0] a, b;
    // R1 reset state
    repeat (3) @(negedge clk);
    n_cmp++;
    if (res_valid !== 1'b0 || res_data !== '0) begin
      n_bad++;
      $display("FAIL R1 act=%b/%h exp=0/0", res_valid, res_data);
    end
    rst = 1'b0;
    monitor_on = 1'b1;

    // R3 corners and random, 2x64
    drive(2'd1, 1'b0, '0, '0, "R3 zeros");
    drive(2'd1, 1'b0, '1, '1, "R3 ones");
    drive(2'd1, 1'b0, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, "R3 pattern");
    for (int i = 0; i < 20; i++) drive(2'd1, 1'b0, rnd128(), rnd128(), "R3 random");
    idle(2);
    // R4 4x32, including upper src_b bits that must not matter
    for (int i = 0; i < 20; i++) drive(2'd1, 1'b1, rnd128(), rnd128(), "R4 random");
    a = rnd128(); b = rnd128();
    drive(2'd1, 1'b1, a, {96'h0, b[31:0]}, "R4 b upper zero");
    drive(2'd1, 1'b1, a, {~b[127:32], b[31:0]}, "R4 b upper flipped");
    idle(1);
    // R5 wide tail, R7 view bit irrelevant
    for (int i = 0; i < 20; i++) drive(2'd2, i[0], rnd128(), rnd128(), "R5/R7 wide tail");
    drive(2'd2, 1'b0, '1, {64'h0, 64'h0}, "R5 ones a4");
    // R6 narrow tail, R7 view bit irrelevant
    for (int i = 0; i < 20; i++) drive(2'd3, i[0], rnd128(), rnd128(), "R6/R7 narrow tail");
    drive(2'd3, 1'b1, '1, '1, "R6 ones");
    idle(3);
    // R8 reserved mode
    drive(2'd0, 1'b0, rnd128(), rnd128(), "R8 reserved");
    drive(2'd0, 1'b1, '1, '1, "R8 reserved ones");
    // mixed back to back
    for (int i = 0; i < 30; i++) drive(2'($urandom), 1'($urandom), rnd128(), rnd128(), "R2 mixed stream");
    idle(4);
    monitor_on = 1'b0;
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R2 watchdog expired act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule